// File: doc/BRIEF.md
# Transceiver Reconfiguration Init Sequencer

This block drives a short, one-time write preamble into a dynamic transceiver reconfiguration controller while the system comes up. It is started while the transceiver power-down or receiver analog reset is held. It puts the controller into channel-reconfiguration mode and writes two preloaded words to controller addresses 0 and 1. These are the leading words of the default configuration image. Each write waits for the controller to be idle and to report a ready address.

After the second word, the block waits for the controller's busy flag to drop. It then pulses the controller's address-clear input so that the address pointer returns to zero. Done is raised and held from then on. A sticky timeout flag reports a busy phase that lasts too long after a write. The wait still runs to completion when the flag is set.

Top module: `xcvr_cfg_preamble`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. In idle `wr_o`, `addr_clr_o`, `done_o` and `timeout_o` are low, `mode_o` is 3'b000 and `data_o` is all zeros.
- R2: The sequence starts only on a clock edge where `start_i` and `hold_i` (power-down or analog reset asserted) are both high. A start request while `hold_i` is low is ignored.
- R3: `mode_o` equals 3'b001 from the cycle after the start is accepted up to and including the address-clear cycle. It equals 3'b000 in idle and once done.
- R4: `wr_o` is a single-cycle pulse. It is raised only while `busy_i` is low, `addr_rdy_i` is high and `cur_addr_i` equals the index of the word being written (0 first, then 1). Exactly two pulses occur per sequence.
- R5: `data_o` carries `word0_i` from the first write cycle until busy drops after that write. It then carries `word1_i` from the second write cycle until busy drops after that write.
- R6: After the second write the block waits until `busy_i` is sampled low. It then raises `addr_clr_o` for exactly one cycle.
- R7: `done_o` rises in the cycle after the `addr_clr_o` pulse and stays high until reset. Further start requests cause no writes.
- R8: If `busy_i` is sampled high on TIMEOUT_CYC consecutive edges in a post-write wait, `timeout_o` goes high and stays high until reset. The sequence still completes once busy drops.
- R9: With ADDR_CHECK = 0 the value of `cur_addr_i` is ignored. A write then needs only busy low and address-ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run the preamble |
| hold_i | input | 1 | Power-down or receiver analog reset is asserted |
| busy_i | input | 1 | Controller busy |
| addr_rdy_i | input | 1 | Controller reports address ready for a write |
| cur_addr_i | input | AW | Controller's current address |
| word0_i | input | DW | Default image word for address 0 |
| word1_i | input | DW | Default image word for address 1 |
| mode_o | output | 3 | Controller mode select |
| wr_o | output | 1 | Write-all strobe |
| data_o | output | DW | Write data |
| addr_clr_o | output | 1 | Address-counter reset pulse |
| done_o | output | 1 | Preamble finished |
| timeout_o | output | 1 | Busy stayed high too long in a wait |

## Verification
The main instance is built with a 16-bit data word and TIMEOUT_CYC = 6. This lets a busy phase reach the timeout threshold in a handful of cycles, so the exact edge at which the flag trips can be checked. A second instance uses ADDR_CHECK = 0 and ties its address input to 9, a value that never matches. That instance must still issue both writes. The main instance receives a wrong address, a busy controller and a not-ready controller in turn, and each of these must hold back its strobe.

// File: rtl/xcvr_cfg_pkg.sv
package xcvr_cfg_pkg;

   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_CHAN = 3'b001;
   localparam logic [MODE_W-1:0] MODE_OFF  = 3'b000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WR0,
      ST_WT0,
      ST_WR1,
      ST_WT1,
      ST_CLR,
      ST_DONE
   } seq_state_e;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_W0,
      SEL_W1
   } word_sel_e;

endpackage

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
   import xcvr_cfg_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      start_i,
   input  logic      hold_i,
   input  logic      busy_i,
   input  logic      addr_rdy_i,
   input  logic      addr_ok0_i,
   input  logic      addr_ok1_i,
   output logic      wr_o,
   output word_sel_e sel_o,
   output logic      mode_act_o,
   output logic      clr_o,
   output logic      done_o,
   output logic      wait_o
);

   seq_state_e state_q, state_d;
   logic       fire0, fire1;

   assign fire0 = (state_q == ST_WR0) && !busy_i && addr_rdy_i && addr_ok0_i;
   assign fire1 = (state_q == ST_WR1) && !busy_i && addr_rdy_i && addr_ok1_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start_i && hold_i) state_d = ST_SETUP;
         ST_SETUP: state_d = ST_WR0;
         ST_WR0:   if (fire0) state_d = ST_WT0;
         ST_WT0:   if (!busy_i) state_d = ST_WR1;
         ST_WR1:   if (fire1) state_d = ST_WT1;
         ST_WT1:   if (!busy_i) state_d = ST_CLR;
         ST_CLR:   state_d = ST_DONE;
         ST_DONE:  state_d = ST_DONE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   always_comb begin
      unique case (state_q)
         ST_WR0, ST_WT0: sel_o = SEL_W0;
         ST_WR1, ST_WT1: sel_o = SEL_W1;
         default:        sel_o = SEL_NONE;
      endcase
   end

   assign wr_o       = fire0 || fire1;
   assign mode_act_o = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign clr_o      = (state_q == ST_CLR);
   assign done_o     = (state_q == ST_DONE);
   assign wait_o     = (state_q == ST_WT0) || (state_q == ST_WT1);

endmodule

// File: rtl/cfg_busy_watch.sv
module cfg_busy_watch #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_i,
   input  logic busy_i,
   output logic trip_o
);

   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;
   logic          trip_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         trip_q <= 1'b0;
      end else if (arm_i && busy_i) begin
         if (cnt_q == CW'(LIMIT - 1)) trip_q <= 1'b1;
         else                         cnt_q  <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   assign trip_o = trip_q;

endmodule

// File: rtl/cfg_word_sel.sv
module cfg_word_sel
   import xcvr_cfg_pkg::*;
#(
   parameter int DW = 32
) (
   input  word_sel_e         sel_i,
   input  logic [DW-1:0]     w0_i,
   input  logic [DW-1:0]     w1_i,
   output logic [DW-1:0]     data_o
);

   always_comb begin
      unique case (sel_i)
         SEL_W0:  data_o = w0_i;
         SEL_W1:  data_o = w1_i;
         default: data_o = '0;
      endcase
   end

endmodule

// File: rtl/xcvr_cfg_preamble.sv
module xcvr_cfg_preamble
   import xcvr_cfg_pkg::*;
#(
   parameter int DW          = 32,
   parameter int AW          = 6,
   parameter int TIMEOUT_CYC = 1024,
   parameter bit ADDR_CHECK  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              hold_i,
   input  logic              busy_i,
   input  logic              addr_rdy_i,
   input  logic [AW-1:0]     cur_addr_i,
   input  logic [DW-1:0]     word0_i,
   input  logic [DW-1:0]     word1_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              wr_o,
   output logic [DW-1:0]     data_o,
   output logic              addr_clr_o,
   output logic              done_o,
   output logic              timeout_o
);

   if (DW < 1) begin : g_bad_dw
      $error("xcvr_cfg_preamble: DW must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("xcvr_cfg_preamble: AW must be at least 1");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_to
      $error("xcvr_cfg_preamble: TIMEOUT_CYC must be at least 2");
   end

   logic      ok0, ok1;
   logic      mode_act;
   logic      in_wait;
   word_sel_e sel;

   if (ADDR_CHECK) begin : g_addr_match
      assign ok0 = (cur_addr_i == AW'(0));
      assign ok1 = (cur_addr_i == AW'(1));
   end else begin : g_addr_free
      logic unused_addr;
      assign unused_addr = ^cur_addr_i;
      assign ok0 = 1'b1;
      assign ok1 = 1'b1;
   end

   cfg_seq_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .hold_i     (hold_i),
      .busy_i     (busy_i),
      .addr_rdy_i (addr_rdy_i),
      .addr_ok0_i (ok0),
      .addr_ok1_i (ok1),
      .wr_o       (wr_o),
      .sel_o      (sel),
      .mode_act_o (mode_act),
      .clr_o      (addr_clr_o),
      .done_o     (done_o),
      .wait_o     (in_wait)
   );

   cfg_word_sel #(.DW(DW)) u_sel (
      .sel_i  (sel),
      .w0_i   (word0_i),
      .w1_i   (word1_i),
      .data_o (data_o)
   );

   cfg_busy_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
      .clk    (clk),
      .rst    (rst),
      .arm_i  (in_wait),
      .busy_i (busy_i),
      .trip_o (timeout_o)
   );

   assign mode_o = mode_act ? MODE_CHAN : MODE_OFF;

endmodule

// File: rtl/cfg_preamble_chk.sv
module cfg_preamble_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          busy_i,
   input logic          addr_rdy_i,
   input logic          wr_o,
   input logic [DW-1:0] data_o,
   input logic [2:0]    mode_o,
   input logic          addr_clr_o,
   input logic          done_o,
   input logic          timeout_o
);

   a_r4_wr_gated: assert property (@(posedge clk) disable iff (rst)
      wr_o |-> (!busy_i && addr_rdy_i));

   a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
      wr_o |=> !wr_o);

   a_r5_data_held: assert property (@(posedge clk) disable iff (rst)
      wr_o |=> $stable(data_o));

   a_r3_mode_active: assert property (@(posedge clk) disable iff (rst)
      (wr_o || addr_clr_o) |-> (mode_o == 3'b001));

   a_r6_clr_after_idle: assert property (@(posedge clk) disable iff (rst)
      addr_clr_o |-> !$past(busy_i));

   a_r7_done_follows_clr: assert property (@(posedge clk) disable iff (rst)
      addr_clr_o |=> (done_o && !addr_clr_o));

   a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
      done_o |=> (done_o && !wr_o && !addr_clr_o));

   a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
      timeout_o |=> timeout_o);

endmodule

bind xcvr_cfg_preamble cfg_preamble_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .busy_i     (busy_i),
   .addr_rdy_i (addr_rdy_i),
   .wr_o       (wr_o),
   .data_o     (data_o),
   .mode_o     (mode_o),
   .addr_clr_o (addr_clr_o),
   .done_o     (done_o),
   .timeout_o  (timeout_o)
);

// File: tb/xcvr_cfg_preamble_test.sv
`timescale 1ns/1ps
module xcvr_cfg_preamble_test;

   localparam int DW  = 16;
   localparam int AW  = 6;
   localparam int TO  = 6;
   localparam logic [DW-1:0] W0 = 16'hA5C3;
   localparam logic [DW-1:0] W1 = 16'h1E7F;

   logic clk = 1'b0;
   logic rst = 1'b1, rst2 = 1'b1;
   logic start = 1'b0, hold = 1'b0, busy = 1'b0, rdy = 1'b0;
   logic [AW-1:0] addr = '0;

   logic [2:0]    mode,  mode2;
   logic          wr,    wr2;
   logic [DW-1:0] data,  data2;
   logic          clr,   clr2;
   logic          done,  done2;
   logic          tout,  tout2;

   int total = 0;
   int bad   = 0;
   int wr_cnt = 0;

   always #4 clk = ~clk;

   xcvr_cfg_preamble #(.DW(DW), .AW(AW), .TIMEOUT_CYC(TO), .ADDR_CHECK(1'b1)) uut (
      .clk(clk), .rst(rst), .start_i(start), .hold_i(hold), .busy_i(busy),
      .addr_rdy_i(rdy), .cur_addr_i(addr), .word0_i(W0), .word1_i(W1),
      .mode_o(mode), .wr_o(wr), .data_o(data), .addr_clr_o(clr),
      .done_o(done), .timeout_o(tout));

   xcvr_cfg_preamble #(.DW(DW), .AW(AW), .TIMEOUT_CYC(TO), .ADDR_CHECK(1'b0)) uut_na (
      .clk(clk), .rst(rst2), .start_i(start), .hold_i(hold), .busy_i(busy),
      .addr_rdy_i(rdy), .cur_addr_i(6'd9), .word0_i(W0), .word1_i(W1),
      .mode_o(mode2), .wr_o(wr2), .data_o(data2), .addr_clr_o(clr2),
      .done_o(done2), .timeout_o(tout2));

   always @(negedge clk) if (!rst && wr) wr_cnt++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      tick(); tick();
      #2;
      chk("R1 wr",      32'(wr),   0);
      chk("R1 clr",     32'(clr),  0);
      chk("R1 done",    32'(done), 0);
      chk("R1 timeout", 32'(tout), 0);
      chk("R1 mode",    32'(mode), 0);
      chk("R1 data",    32'(data), 0);
      tick();
      rst = 1'b0;
   endtask

   task automatic t_start_gated();
      start = 1'b1; hold = 1'b0;
      tick(); tick();
      #2;
      chk("R2 no start without hold", 32'(mode), 0);
      start = 1'b0;
   endtask

   task automatic t_main();
      int base;
      base = wr_cnt;
      tick(); start = 1'b1; hold = 1'b1; busy = 1'b0; rdy = 1'b0; addr = '0;
      #2 chk("R3 idle mode", 32'(mode), 0);
      tick(); start = 1'b0;
      #2 chk("R3 setup mode", 32'(mode), 1);
      chk("R4 setup no wr", 32'(wr), 0);
      tick();
      #2 chk("R4 no wr when not ready", 32'(wr), 0);
      tick(); rdy = 1'b1; busy = 1'b1;
      #2 chk("R4 no wr when busy", 32'(wr), 0);
      tick(); busy = 1'b0; addr = 6'd1;
      #2 chk("R4 no wr on wrong address", 32'(wr), 0);
      tick(); addr = 6'd0;
      #2 chk("R4 first wr", 32'(wr), 1);
      chk("R5 first data", 32'(data), 32'(W0));
      tick(); busy = 1'b1; rdy = 1'b0;
      #2 chk("R4 wr single", 32'(wr), 0);
      chk("R5 data held", 32'(data), 32'(W0));
      for (int i = 0; i < 3; i++) begin
         tick();
         #2 chk("R5 data held busy", 32'(data), 32'(W0));
      end
      tick(); busy = 1'b0;
      #2 chk("R5 data held last busy", 32'(data), 32'(W0));
      tick(); addr = 6'd1;
      #2 chk("R4 second wr waits ready", 32'(wr), 0);
      chk("R5 second data", 32'(data), 32'(W1));
      tick(); rdy = 1'b1;
      #2 chk("R4 second wr", 32'(wr), 1);
      chk("R5 second data at wr", 32'(data), 32'(W1));
      tick(); busy = 1'b1; rdy = 1'b0;
      #2 chk("R6 no clr while busy", 32'(clr), 0);
      chk("R5 second data held", 32'(data), 32'(W1));
      tick(); busy = 1'b0;
      #2 chk("R6 no clr yet", 32'(clr), 0);
      tick();
      #2 chk("R6 clr pulse", 32'(clr), 1);
      chk("R7 done not yet", 32'(done), 0);
      chk("R3 mode at clr", 32'(mode), 1);
      tick();
      #2 chk("R6 clr one cycle", 32'(clr), 0);
      chk("R7 done high", 32'(done), 1);
      chk("R3 mode off at done", 32'(mode), 0);
      start = 1'b1; hold = 1'b1; rdy = 1'b1; addr = '0;
      for (int i = 0; i < 4; i++) begin
         tick();
         #2 chk("R7 done sticky", 32'(done), 1);
         chk("R7 no wr after done", 32'(wr), 0);
      end
      start = 1'b0;
      chk("R4 two writes", 32'(wr_cnt - base), 2);
      chk("R8 no timeout on short busy", 32'(tout), 0);
   endtask

   task automatic t_timeout();
      rst = 1'b1;
      tick(); tick();
      #2 chk("R1 done cleared by reset", 32'(done), 0);
      tick(); rst = 1'b0; start = 1'b1; hold = 1'b1; busy = 1'b0; rdy = 1'b1; addr = '0;
      tick(); start = 1'b0;
      tick();
      #2 chk("R4 wr when ready", 32'(wr), 1);
      tick(); busy = 1'b1; rdy = 1'b0;
      for (int i = 0; i < TO - 1; i++) begin
         tick();
         #2 chk("R8 no timeout before limit", 32'(tout), 0);
      end
      tick();
      #2 chk("R8 timeout at limit", 32'(tout), 1);
      busy = 1'b0;
      tick(); rdy = 1'b1; addr = 6'd1;
      #2 chk("R8 sequence resumes", 32'(wr), 1);
      tick(); rdy = 1'b0;
      tick();
      #2 chk("R6 clr after timeout", 32'(clr), 1);
      tick();
      #2 chk("R8 done after timeout", 32'(done), 1);
      chk("R8 timeout sticky", 32'(tout), 1);
   endtask

   task automatic t_noaddr();
      tick(); rst2 = 1'b0; start = 1'b1; hold = 1'b1; busy = 1'b0; rdy = 1'b1;
      tick(); start = 1'b0;
      tick();
      #2 chk("R9 first wr ignores address", 32'(wr2), 1);
      chk("R9 first data", 32'(data2), 32'(W0));
      tick();
      #2 chk("R9 wr single", 32'(wr2), 0);
      tick();
      #2 chk("R9 second wr ignores address", 32'(wr2), 1);
      chk("R9 second data", 32'(data2), 32'(W1));
      tick();
      tick();
      #2 chk("R9 clr", 32'(clr2), 1);
      tick();
      #2 chk("R9 done", 32'(done2), 1);
   endtask

   initial begin
      t_reset();
      t_start_gated();
      t_main();
      t_timeout();
      t_noaddr();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 50000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule